// File: doc/BRIEF.md
# Padded Boundary-Scan Shift Sequencer

This block drives a four-wire test access port (TCK, TMS, TDI, TDO) to run a single instruction-register or data-register scan on one device in a daisy chain. The caller supplies the target bits and their length, and two pad counts that stand for the bypassed devices ahead of and behind the target. The block builds the stream as the leading pad bits, then the target bits, then the trailing pad bits, and shifts each part least significant bit first. Pad bits are always driven as ones.

The block keeps track of where it last left the port: unknown after reset, test-logic-reset, run-test/idle, or one of the two pause states. From that point it walks into the correct shift state and shifts the whole stream. It then steps once more into the matching pause state and moves on to the stop state chosen for that register kind. Only the TDO bits that line up with the target slice are kept, in `cap_bits`. Each TAP step takes two system clocks: TCK is low for the first and high for the second. TMS and TDI change only when TCK falls, and TDO is sampled as TCK rises.

Top module: `jtag_scan_seq`

## Requirements
- R1: A scan makes exactly pre_cnt + tgt_len + post_cnt TCK rising edges in the shift state. TDI on shift edge i carries target bit (i - pre_cnt) when pre_cnt <= i < pre_cnt + tgt_len.
- R2: TDI is 1 on every shift edge outside the target slice, in both the leading and the trailing pad.
- R3: From run-test/idle the TMS entry steps are 1,0,0 for a data scan (sel_ir = 0) and 1,1,0,0 for an instruction scan (sel_ir = 1). A scan that starts from test-logic-reset is preceded by a single TMS 0.
- R4: From either pause state the entry steps are preceded by two TMS 1 steps, giving 1,1,1,0,0 for data and 1,1,1,1,0,0 for instruction.
- R5: The first scan after reset, when the port position is unknown, is preceded by TMS 1,1,1,1,1,0.
- R6: TMS is 1 only on the last shift edge of the stream. The next edge carries TMS 0 and lands in the matching pause state.
- R7: The stop code (stop_dr for data scans, stop_ir for instruction scans) then selects the parking state. Code 0 or 3 goes to idle with TMS 1,1,0. Code 1 stays in pause with no further step. Code 2 goes to test-logic-reset with five TMS 1 steps.
- R8: After a scan, cap_bits[k] holds the TDO value sampled on shift edge pre_cnt + k for every k < tgt_len. All higher bits are 0.
- R9: When pre_cnt + tgt_len + post_cnt is 0, the last entry step carries TMS 1, so the port passes from capture straight to exit-1 with no shift edge.
- R10: TMS and TDI stay unchanged across each TCK rising edge. While the block is idle, TCK, TMS and TDI are 0.
- R11: A start seen while idle launches a scan and raises busy. A start while busy is ignored. done pulses for one cycle as busy falls, with TCK low.
- R12: cap_bits does not change while the block is idle unless a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; port position becomes unknown |
| start | input | 1 | Launch a scan (sampled while idle) |
| sel_ir | input | 1 | 1 = instruction-register scan, 0 = data-register scan |
| pre_cnt | input | PAD_W | Leading pad bit count |
| tgt_len | input | LEN_W | Target bit count, 0 to TGT_W |
| tgt_bits | input | TGT_W | Target bits, bit 0 shifted first |
| post_cnt | input | PAD_W | Trailing pad bit count |
| stop_dr | input | 2 | Parking code after data scans |
| stop_ir | input | 2 | Parking code after instruction scans |
| tdo | input | 1 | Test data from the chain |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| cap_bits | output | TGT_W | Captured target slice |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the chain |

## Verification
Two things meet on the same system-clock edge: the TCK rise that captures TDO for shift bit i, and the step counter that selects which TDI bit is presented next. The bench puts a behavioural TAP and chain on the pins. The chain returns a known pattern indexed by shift position, and the bench checks that each captured target bit matches the pattern at its own index, not one off. A start pulse is also sent while a scan is running, together with a changed register kind and changed bits. That scan's step count, stream, capture and final port state must match the request that was accepted, not the ignored one.

// File: rtl/jtag_scan_seq.sv
module jtag_scan_seq #(
  parameter int TGT_W = 64,
  parameter int PAD_W = 8,
  parameter int LEN_W = $clog2(TGT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sel_ir,
  input  logic [PAD_W-1:0] pre_cnt,
  input  logic [LEN_W-1:0] tgt_len,
  input  logic [TGT_W-1:0] tgt_bits,
  input  logic [PAD_W-1:0] post_cnt,
  input  logic [1:0]       stop_dr,
  input  logic [1:0]       stop_ir,
  input  logic             tdo,
  output logic             busy,
  output logic             done,
  output logic [TGT_W-1:0] cap_bits,
  output logic             tck,
  output logic             tms,
  output logic             tdi
);
  localparam int CNT_W  = $clog2(2 * ((1 << PAD_W) - 1) + TGT_W + 1);
  localparam int TIDX_W = (TGT_W > 1) ? $clog2(TGT_W) : 1;

  typedef enum logic [1:0] {S_HEAD, S_SHIFT, S_TAIL, S_FIN} phase_t;
  typedef enum logic [2:0] {K_UNK, K_TLR, K_RTI, K_PDR, K_PIR} park_t;

  phase_t             phase;
  park_t              park;
  logic               ph, ir_q;
  logic [1:0]         stop_q;
  logic [CNT_W-1:0]   cnt, tot_q;
  logic [PAD_W-1:0]   pre_q;
  logic [LEN_W-1:0]   len_q;
  logic [TGT_W-1:0]   tgt_q;
  logic [15:0]        hvec;
  logic [3:0]         hlen;
  logic [7:0]         tvec;
  logic [2:0]         tlen;

  // head and tail TMS programs, built when a scan is accepted
  logic [CNT_W-1:0] tot_w;
  logic [5:0]       pv;
  logic [2:0]       pl, el, tl;
  logic [3:0]       ev;
  logic [7:0]       tv;
  logic [1:0]       stop_w;

  assign tot_w  = CNT_W'(pre_cnt) + CNT_W'(tgt_len) + CNT_W'(post_cnt);
  assign stop_w = sel_ir ? stop_ir : stop_dr;

  always_comb begin
    case (park)
      K_UNK:   begin pv = 6'b011111; pl = 3'd6; end
      K_TLR:   begin pv = 6'b000000; pl = 3'd1; end
      K_RTI:   begin pv = 6'b000000; pl = 3'd0; end
      default: begin pv = 6'b000011; pl = 3'd2; end
    endcase
    if (sel_ir) begin ev = {tot_w == '0, 3'b011}; el = 3'd4; end
    else        begin ev = {1'b0, tot_w == '0, 2'b01}; el = 3'd3; end
    case (stop_w)
      2'd1:    begin tv = 8'b0000_0000; tl = 3'd1; end
      2'd2:    begin tv = 8'b0011_1110; tl = 3'd6; end
      default: begin tv = 8'b0000_0110; tl = 3'd4; end
    endcase
  end

  // per-step TMS/TDI and end-of-part detection
  logic              in_tgt, last_step, cur_tms, cur_tdi;
  logic [TIDX_W-1:0] tidx;

  assign in_tgt = (cnt >= CNT_W'(pre_q)) && (cnt < CNT_W'(pre_q) + CNT_W'(len_q));
  assign tidx   = TIDX_W'(cnt - CNT_W'(pre_q));

  always_comb begin
    case (phase)
      S_HEAD:  begin last_step = (cnt == CNT_W'(hlen - 4'd1)); cur_tms = hvec[cnt[3:0]]; cur_tdi = 1'b0; end
      S_SHIFT: begin last_step = (cnt == tot_q - 1'b1); cur_tms = last_step; cur_tdi = in_tgt ? tgt_q[tidx] : 1'b1; end
      S_TAIL:  begin last_step = (cnt == CNT_W'(tlen - 3'd1)); cur_tms = tvec[cnt[2:0]]; cur_tdi = 1'b0; end
      default: begin last_step = 1'b1; cur_tms = 1'b0; cur_tdi = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= S_HEAD; park <= K_UNK; ph <= 1'b0; ir_q <= 1'b0; stop_q <= '0;
      cnt <= '0; tot_q <= '0; pre_q <= '0; len_q <= '0; tgt_q <= '0;
      hvec <= '0; hlen <= '0; tvec <= '0; tlen <= '0;
      busy <= 1'b0; done <= 1'b0; cap_bits <= '0; tck <= 1'b0; tms <= 1'b0; tdi <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; ph <= 1'b0; phase <= S_HEAD; cnt <= '0;
          ir_q <= sel_ir; stop_q <= stop_w; tot_q <= tot_w;
          pre_q <= pre_cnt; len_q <= tgt_len; tgt_q <= tgt_bits;
          hvec <= 16'(pv) | (16'(ev) << pl); hlen <= 4'(pl) + 4'(el);
          tvec <= tv; tlen <= tl; cap_bits <= '0;
        end
      end else if (!ph) begin
        tck <= 1'b0;
        if (phase == S_FIN) begin
          busy <= 1'b0; done <= 1'b1; tms <= 1'b0; tdi <= 1'b0;
          case (stop_q)
            2'd1:    park <= ir_q ? K_PIR : K_PDR;
            2'd2:    park <= K_TLR;
            default: park <= K_RTI;
          endcase
        end else begin
          tms <= cur_tms; tdi <= cur_tdi; ph <= 1'b1;
        end
      end else begin
        tck <= 1'b1; ph <= 1'b0;
        if (phase == S_SHIFT && in_tgt) cap_bits[tidx] <= tdo;
        if (!last_step) cnt <= cnt + 1'b1;
        else begin
          cnt <= '0;
          case (phase)
            S_HEAD:  phase <= (tot_q == '0) ? S_TAIL : S_SHIFT;
            S_SHIFT: phase <= S_TAIL;
            default: phase <= S_FIN;
          endcase
        end
      end
    end
  end
endmodule

module jtag_scan_seq_chk #(
  parameter int TGT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             tck,
  input logic             tms,
  input logic             tdi,
  input logic [TGT_W-1:0] cap_bits
);
  AST_EDGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n) $rose(tck) |-> ($stable(tms) && $stable(tdi))); // R10
  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!tck && !tms && !tdi)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done && !tck)); // R11
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R11
  AST_CAP_HELD:    assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(cap_bits)); // R12
endmodule

bind jtag_scan_seq jtag_scan_seq_chk #(.TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .tck(tck), .tms(tms), .tdi(tdi), .cap_bits(cap_bits)
);

// File: tb/tb_jtag_scan_seq.sv
module tb_jtag_scan_seq;
  localparam int TGT_W = 64;
  localparam int PAD_W = 8;
  localparam int LEN_W = 7;

  localparam logic [3:0] T_TLR = 4'd0,  T_RTI = 4'd1,  T_SDS = 4'd2,  T_CDR = 4'd3,
                         T_SDR = 4'd4,  T_E1D = 4'd5,  T_PDR = 4'd6,  T_E2D = 4'd7,
                         T_UDR = 4'd8,  T_SIS = 4'd9,  T_CIR = 4'd10, T_SIR = 4'd11,
                         T_E1I = 4'd12, T_PIR = 4'd13, T_E2I = 4'd14, T_UIR = 4'd15;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0, start = 1'b0, sel_ir = 1'b0, tdo = 1'b0;
  logic [PAD_W-1:0] pre_cnt = '0, post_cnt = '0;
  logic [LEN_W-1:0] tgt_len = '0;
  logic [TGT_W-1:0] tgt_bits = '0;
  logic [1:0]       stop_dr = '0, stop_ir = '0;
  logic             busy, done, tck, tms, tdi;
  logic [TGT_W-1:0] cap_bits;

  jtag_scan_seq #(.TGT_W(TGT_W), .PAD_W(PAD_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_ir(sel_ir), .pre_cnt(pre_cnt),
    .tgt_len(tgt_len), .tgt_bits(tgt_bits), .post_cnt(post_cnt), .stop_dr(stop_dr),
    .stop_ir(stop_ir), .tdo(tdo), .busy(busy), .done(done), .cap_bits(cap_bits),
    .tck(tck), .tms(tms), .tdi(tdi)
  );

  int n_chk = 0, n_fail = 0;
  int park = 0; // 0 unknown, 1 reset, 2 idle, 3 pause-dr, 4 pause-ir

  function automatic logic patt(int i);
    logic [15:0] v;
    v = 16'(i * 40503 + 11);
    return v[9] ^ v[3];
  endfunction

  function automatic logic [3:0] tap_next(logic [3:0] s, logic m);
    case (s)
      T_TLR: return m ? T_TLR : T_RTI;
      T_RTI: return m ? T_SDS : T_RTI;
      T_SDS: return m ? T_SIS : T_CDR;
      T_CDR, T_SDR: return m ? T_E1D : T_SDR;
      T_E1D: return m ? T_UDR : T_PDR;
      T_PDR: return m ? T_E2D : T_PDR;
      T_E2D: return m ? T_UDR : T_SDR;
      T_SIS: return m ? T_TLR : T_CIR;
      T_CIR, T_SIR: return m ? T_E1I : T_SIR;
      T_E1I: return m ? T_UIR : T_PIR;
      T_PIR: return m ? T_E2I : T_PIR;
      T_E2I: return m ? T_UIR : T_SIR;
      default: return m ? T_SDS : T_RTI;
    endcase
  endfunction

  logic [3:0] tap = T_SIR;
  bit tms_log [0:1023];
  bit tdi_log [0:1023];
  int ecnt = 0, scnt = 0;

  always @(posedge tck) begin
    if (ecnt < 1024) tms_log[ecnt] = tms;
    ecnt = ecnt + 1;
    if (tap == T_SDR || tap == T_SIR) begin
      if (scnt < 1024) tdi_log[scnt] = tdi;
      scnt = scnt + 1;
    end
    if (tap == T_CDR || tap == T_CIR) scnt = 0;
    tap = tap_next(tap, tms);
  end

  always @(negedge tck) tdo <= patt(scnt);

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit s, input int pre, input int len, input int post,
                        input int stp, input logic [TGT_W-1:0] tgt, input bit poke);
    bit hq[$];
    bit tq[$];
    int tot, hl, tl, bad_t, bad_p, bad_m, bad_h, bad_q;
    logic [TGT_W-1:0] exp_cap;
    logic [3:0] exp_tap;
    string hreq;
    bit seen;
    tot = pre + len + post;
    case (park)
      0: begin hreq = "R5"; hq = '{1, 1, 1, 1, 1, 0}; end
      1: begin hreq = "R3"; hq = '{0}; end
      2: hreq = "R3";
      default: begin hreq = "R4"; hq = '{1, 1}; end
    endcase
    hq.push_back(1);
    if (s) hq.push_back(1);
    hq.push_back(0);
    hq.push_back(tot == 0);
    case (stp)
      1: tq = '{0};
      2: tq = '{0, 1, 1, 1, 1, 1};
      default: tq = '{0, 1, 1, 0};
    endcase
    hl = hq.size();
    tl = tq.size();
    @(negedge clk);
    ecnt = 0;
    scnt = 0;
    sel_ir = s; pre_cnt = PAD_W'(pre); tgt_len = LEN_W'(len); post_cnt = PAD_W'(post);
    tgt_bits = tgt; stop_dr = 2'(stp); stop_ir = 2'(stp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      sel_ir = ~s; tgt_bits = ~tgt; tgt_len = LEN_W'(1); stop_dr = 2'd2; stop_ir = 2'd2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 0;
    for (int c = 0; c < 4000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen && !busy && !tck, "R11", "done pulse at end of scan", {busy, tck}, 0);
    check(ecnt == hl + tot + tl, poke ? "R11" : "R6", "total TCK edges", ecnt, hl + tot + tl);
    bad_h = 0;
    for (int i = 0; i < hl; i++) if (tms_log[i] != hq[i]) bad_h++;
    check(bad_h == 0, hreq, "entry TMS steps mismatched", bad_h, 0);
    if (tot == 0) check(scnt == 0, "R9", "shift edges on empty stream", scnt, 0);
    else check(scnt == tot, "R1", "shift edge count", scnt, tot);
    bad_t = 0; bad_p = 0; bad_m = 0;
    for (int i = 0; i < tot; i++) begin
      if (i >= pre && i < pre + len) begin
        if (tdi_log[i] != tgt[i - pre]) bad_t++;
      end else if (tdi_log[i] != 1'b1) bad_p++;
      if (tms_log[hl + i] != (i == tot - 1)) bad_m++;
    end
    check(bad_t == 0, "R1", "target TDI bits mismatched", bad_t, 0);
    check(bad_p == 0, "R2", "pad TDI bits not one", bad_p, 0);
    check(bad_m == 0, "R6", "shift TMS bits mismatched", bad_m, 0);
    bad_q = 0;
    for (int i = 0; i < tl; i++) if (tms_log[hl + tot + i] != tq[i]) bad_q++;
    check(bad_q == 0, "R7", "exit TMS steps mismatched", bad_q, 0);
    exp_cap = '0;
    for (int k = 0; k < len; k++) exp_cap[k] = patt(pre + k);
    check(cap_bits == exp_cap, "R8", "captured target slice", cap_bits, exp_cap);
    case (stp)
      1: begin exp_tap = s ? T_PIR : T_PDR; park = s ? 4 : 3; end
      2: begin exp_tap = T_TLR; park = 1; end
      default: begin exp_tap = T_RTI; park = 2; end
    endcase
    check(tap == exp_tap, "R7", "parked port state", tap, exp_tap);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int pres[3];
    int lens[4];
    int posts[2];
    int op;
    logic [TGT_W-1:0] t;
    logic [TGT_W-1:0] held;
    pres = '{0, 1, 3};
    lens = '{0, 1, 5, 64};
    posts = '{0, 2};
    repeat (3) @(negedge clk);
    check(!busy && !done && cap_bits == '0, "R11", "reset outputs", {busy, done}, 0);
    check(!tck && !tms && !tdi, "R10", "port idle after reset", {tck, tms, tdi}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    op = 0;
    for (int s = 0; s < 2; s++)
      for (int stp = 0; stp < 4; stp++)
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 4; b++)
            for (int c = 0; c < 2; c++) begin
              t = {32'h9E3779B9, 32'h7F4A7C15} ^ (64'(op) * 64'h0000_0001_0001_0101);
              run_op(s[0], pres[a], lens[b], posts[c], stp, t, 1'b0);
              op++;
            end
    run_op(1'b0, 255, 64, 255, 1, 64'hA5A5_0F0F_3C3C_9696, 1'b0);
    run_op(1'b1, 255, 7, 255, 0, 64'h0000_0000_0000_005A, 1'b0);
    run_op(1'b0, 2, 9, 1, 0, 64'h0000_0000_0000_0136, 1'b1);
    held = cap_bits;
    @(negedge clk);
    tgt_bits = '1; sel_ir = 1'b1; tgt_len = LEN_W'(3);
    repeat (6) @(negedge clk);
    check(cap_bits == held && !busy, "R12", "capture held while idle", cap_bits, held);
    check(!tck && !tms && !tdi, "R10", "port quiet while idle", {tck, tms, tdi}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule